// File: doc/BRIEF.md
# Display Controller Memory-Mapped Register Window

This block is the register front end of a VGA-compatible display controller. It is reached through one memory window. A request bus supplies an address, a size code, a write flag and write data. The block decodes each access to one of four sub-windows and converts it into the byte or halfword operations that the back-end register ports expect. It returns merged read data with a one-cycle response pulse.

The four sub-windows are as follows:
- A read-only monitor identification table.
- A byte-wide remap of the legacy I/O ports, where wide accesses are split into ordered little-endian byte steps. This lets an index/data port pair be written in one access.
- An extended-mode register file whose register number comes from the address.
- An optional extension block. It reports its own size and holds the framebuffer byte-order flag.

The legacy and extended register files are simple stubs that stand in for the real display logic. The identification table and the extension block can each be removed by a parameter. The revision number the block reports depends on whether the extension block is present.

Top module: `dwin_mmio_window`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` is 0. The byte-order flag is little-endian, so `fb_big_endian` is 0.
- R2: The legacy remap covers offsets 0x400–0x41F. A byte access at 0x400+N reaches legacy port 0x3C0+N. Every port is a plain byte register except port 0x3C5. Port 0x3C5 reads and writes entry `port(0x3C4)[2:0]` of an 8-entry indexed bank.
- R3: A 16-bit legacy write first writes its bits 7:0 to port N. It then writes bits 15:8 to port N+1. A single halfword write to 0x404 therefore selects a bank entry and fills it.
- R4: Wide legacy reads merge port N into bits 7:0, port N+1 into bits 15:8, and so on. A 32-bit access is handled as two halves, lower half first, for four byte steps in ascending port order. Byte steps that fall past 0x41F are dropped and read as 0.
- R5: The extended file holds 16 registers of 16 bits at 0x500–0x51F. The register number is `(addr-0x500)>>1`. A write of any size stores `wdata[15:0]`. A read returns the register zero-extended to 32 bits.
- R6: The extension block at 0x600–0x607 acts only on size code 2 (32 bits). Any other size reads 0 and writes nothing. Offset 0 reads 8, the block's size in bytes. Offsets other than 0 and 4 read 0.
- R7: Offset 4 of the extension block reads 0xBEBEBEBE when the flag is big-endian and 0x1E1E1E1E when it is little-endian. Writing one of these two codes sets the flag to match. Writing any other value leaves the flag unchanged. `fb_big_endian` shows the flag.
- R8: The identification table spans 0x000–0x0FF and cannot be written. Byte i holds `(37*i+11) mod 256`. Wide reads merge bytes little-endian, and bytes past 0x0FF read 0.
- R9: With `ID_EN=0`, the identification table reads 0. With `QX_EN=0`, the extension block reads 0 and ignores writes. `revision_id` is 2 with the extension block present and 1 without it.
- R10: Offsets outside every sub-window read 0, and writes to them change nothing.
- R11: Size codes are 0 = 1 byte, 1 = 2 bytes, and 2 or 3 = 4 bytes. A request is taken when `req_valid` and `req_ready` are both 1. After that, `req_ready` stays low for n+1 cycles on a legacy access of n bytes and for 2 cycles on any other access. `resp_valid` is a one-cycle pulse in the last of those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the window |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Write data, little-endian lanes |
| req_ready | output | 1 | Idle and able to take a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 32 | Merged read data, valid with resp_valid |
| fb_big_endian | output | 1 | Framebuffer byte-order flag |
| revision_id | output | 8 | Reported revision |

## Verification
Legacy accesses are tried at byte, halfword and word size. Halfword writes of an index/data pair land in the bank entry chosen by the new index, not the old one, which shows the split order. Word reads and writes starting at several offsets show the lane merge and the drop past the window end, and the width of each access is confirmed by how long `req_ready` stays low. The byte-order register receives both codes, a stray value and a narrow write, which tells a matching write apart from one that must be ignored. A second instance with both options removed shows the option gating and the revision difference.

// File: rtl/dwin_pkg.sv
package dwin_pkg;

    localparam int AW = 12;
    localparam int DW = 32;

    localparam logic [AW-1:0] ID_BASE  = 12'h000;
    localparam logic [AW-1:0] LEG_BASE = 12'h400;
    localparam logic [AW-1:0] XR_BASE  = 12'h500;
    localparam logic [AW-1:0] QX_BASE  = 12'h600;

    localparam int ID_SPAN     = 256;
    localparam int LEG_SPAN    = 32;
    localparam int XR_REGS     = 16;
    localparam int XR_SPAN     = 2 * XR_REGS;
    localparam int QX_SPAN     = 8;
    localparam int SEQ_ENTRIES = 8;

    localparam int LEG_OW = $clog2(LEG_SPAN);
    localparam int XR_IW  = $clog2(XR_REGS);
    localparam int QX_OW  = $clog2(QX_SPAN);
    localparam int SEQ_IW = $clog2(SEQ_ENTRIES);

    localparam logic [LEG_OW-1:0] LEG_IDX_OFF = 5'd4;
    localparam logic [LEG_OW-1:0] LEG_DAT_OFF = 5'd5;

    localparam logic [QX_OW-1:0] QX_OFF_SIZE  = 3'd0;
    localparam logic [QX_OW-1:0] QX_OFF_ORDER = 3'd4;

    localparam logic [DW-1:0] CODE_BE = 32'hBEBE_BEBE;
    localparam logic [DW-1:0] CODE_LE = 32'h1E1E_1E1E;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_ID,
        RG_LEG,
        RG_XR,
        RG_QX
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_RESP
    } st_e;

    typedef struct packed {
        logic            we;
        size_e           size;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdata;
    } bus_req_t;

    function automatic logic [1:0] last_step(size_e s);
        case (s)
            SZ_BYTE: return 2'd0;
            SZ_HALF: return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic in_span(logic [AW-1:0] a, logic [AW-1:0] base, int span);
        logic [AW-1:0] rel;
        rel = a - base;
        return rel < AW'(span);
    endfunction

    function automatic region_e decode(logic [AW-1:0] a, bit id_en, bit qx_en);
        if (id_en && in_span(a, ID_BASE, ID_SPAN))  return RG_ID;
        if (in_span(a, LEG_BASE, LEG_SPAN))         return RG_LEG;
        if (in_span(a, XR_BASE, XR_SPAN))           return RG_XR;
        if (qx_en && in_span(a, QX_BASE, QX_SPAN))  return RG_QX;
        return RG_NONE;
    endfunction

    function automatic logic [7:0] id_byte(logic [7:0] i);
        return 8'((int'(i) * 37 + 11) & 255);
    endfunction

endpackage

// File: rtl/dwin_legacy.sv
module dwin_legacy
    import dwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              we,
    input  logic [LEG_OW-1:0] off,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    logic [7:0] port_q [LEG_SPAN];
    logic [7:0] bank_q [SEQ_ENTRIES];
    logic [SEQ_IW-1:0] sel;

    assign sel   = port_q[LEG_IDX_OFF][SEQ_IW-1:0];
    assign rdata = (off == LEG_DAT_OFF) ? bank_q[sel] : port_q[off];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LEG_SPAN; i++)    port_q[i] <= '0;
            for (int i = 0; i < SEQ_ENTRIES; i++) bank_q[i] <= '0;
        end else if (stb && we) begin
            if (off == LEG_DAT_OFF) bank_q[sel] <= wdata;
            else                    port_q[off] <= wdata;
        end
    end

endmodule

// File: rtl/dwin_xregs.sv
module dwin_xregs
    import dwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic             we,
    input  logic [XR_IW-1:0] idx,
    input  logic [15:0]      wdata,
    output logic [15:0]      rdata
);

    logic [15:0] file_q [XR_REGS];

    assign rdata = file_q[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < XR_REGS; i++) file_q[i] <= '0;
        end else if (stb && we) begin
            file_q[idx] <= wdata;
        end
    end

endmodule

// File: rtl/dwin_qext.sv
module dwin_qext
    import dwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic             we,
    input  logic [QX_OW-1:0] off,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             big_endian
);

    logic be_q;

    assign big_endian = be_q;

    always_comb begin
        case (off)
            QX_OFF_SIZE:  rdata = DW'(QX_SPAN);
            QX_OFF_ORDER: rdata = be_q ? CODE_BE : CODE_LE;
            default:      rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            be_q <= 1'b0;
        end else if (stb && we && off == QX_OFF_ORDER) begin
            if (wdata == CODE_BE)      be_q <= 1'b1;
            else if (wdata == CODE_LE) be_q <= 1'b0;
        end
    end

    // R7: the flag moves only after a matching code was written to the order register
    p_order_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(be_q) |-> $past(stb && we && off == QX_OFF_ORDER &&
                                 (wdata == CODE_BE || wdata == CODE_LE)));

endmodule

// File: rtl/dwin_seq.sv
module dwin_seq
    import dwin_pkg::*;
#(
    parameter bit ID_EN = 1'b1,
    parameter bit QX_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_size,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DW-1:0]     resp_rdata,
    output logic              leg_stb,
    output logic              leg_we,
    output logic [LEG_OW-1:0] leg_off,
    output logic [7:0]        leg_wdata,
    input  logic [7:0]        leg_rdata,
    output logic              xr_stb,
    output logic              xr_we,
    output logic [XR_IW-1:0]  xr_idx,
    output logic [15:0]       xr_wdata,
    input  logic [15:0]       xr_rdata,
    output logic              qx_stb,
    output logic              qx_we,
    output logic [QX_OW-1:0]  qx_off,
    output logic [DW-1:0]     qx_wdata,
    input  logic [DW-1:0]     qx_rdata
);

    st_e           st;
    bus_req_t      cur;
    region_e       rgn;
    logic [1:0]    step;
    logic [DW-1:0] acc, acc_nxt, id_word;
    logic [LEG_OW:0] pos;
    logic          leg_hit, running, final_step;

    assign running    = (st == ST_RUN);
    assign final_step = (rgn != RG_LEG) || (step == last_step(cur.size));

    // Legacy byte step position; the window base is span-aligned
    assign pos     = {1'b0, cur.addr[LEG_OW-1:0]} + (LEG_OW+1)'(step);
    assign leg_hit = !pos[LEG_OW];

    assign leg_stb   = running && rgn == RG_LEG && leg_hit;
    assign leg_we    = cur.we;
    assign leg_off   = pos[LEG_OW-1:0];
    assign leg_wdata = cur.wdata[8*step +: 8];

    assign xr_stb   = running && rgn == RG_XR;
    assign xr_we    = cur.we;
    assign xr_idx   = cur.addr[XR_IW:1];
    assign xr_wdata = cur.wdata[15:0];

    assign qx_stb   = running && rgn == RG_QX && cur.size == SZ_WORD;
    assign qx_we    = cur.we;
    assign qx_off   = cur.addr[QX_OW-1:0];
    assign qx_wdata = cur.wdata;

    // Identification table lanes, one per byte of the bus
    for (genvar k = 0; k < DW / 8; k++) begin : g_id_lane
        logic [8:0] ipos;
        assign ipos = {1'b0, cur.addr[7:0]} + 9'(k);
        assign id_word[8*k +: 8] =
            (2'(k) <= last_step(cur.size) && !ipos[8]) ? id_byte(ipos[7:0]) : 8'h00;
    end

    always_comb begin
        acc_nxt = acc;
        if (!cur.we) begin
            case (rgn)
                RG_LEG: if (leg_hit) acc_nxt[8*step +: 8] = leg_rdata;
                RG_XR:  acc_nxt = {16'h0000, xr_rdata};
                RG_QX:  if (qx_stb) acc_nxt = qx_rdata;
                RG_ID:  acc_nxt = id_word;
                default: acc_nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cur  <= '0;
            rgn  <= RG_NONE;
            step <= '0;
            acc  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    cur  <= '{we: req_write, size: size_e'(req_size),
                              addr: req_addr, wdata: req_wdata};
                    rgn  <= decode(req_addr, ID_EN, QX_EN);
                    step <= '0;
                    acc  <= '0;
                    st   <= ST_RUN;
                end
                ST_RUN: begin
                    acc <= acc_nxt;
                    if (final_step) st <= ST_RESP;
                    else            step <= step + 2'd1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (st == ST_IDLE);
    assign resp_valid = (st == ST_RESP);
    assign resp_rdata = acc;

    // R11: a taken request makes the window busy on the next cycle
    p_accept_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R11: the response strobe lasts a single cycle
    p_resp_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    // R3 / R4: later byte steps of a split hit the next port up
    p_leg_order_r3: assert property (@(posedge clk) disable iff (rst)
        (leg_stb && step != 2'd0) |-> (leg_off == LEG_OW'($past(leg_off) + 1'b1)));

endmodule

// File: rtl/dwin_mmio_window.sv
module dwin_mmio_window
    import dwin_pkg::*;
#(
    parameter bit ID_EN = 1'b1,
    parameter bit QX_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [11:0]   req_addr,
    input  logic [1:0]    req_size,
    input  logic [31:0]   req_wdata,
    output logic          req_ready,
    output logic          resp_valid,
    output logic [31:0]   resp_rdata,
    output logic          fb_big_endian,
    output logic [7:0]    revision_id
);

    localparam logic [7:0] REV = QX_EN ? 8'd2 : 8'd1;

    logic              leg_stb, leg_we;
    logic [LEG_OW-1:0] leg_off;
    logic [7:0]        leg_wdata, leg_rdata;
    logic              xr_stb, xr_we;
    logic [XR_IW-1:0]  xr_idx;
    logic [15:0]       xr_wdata, xr_rdata;
    logic              qx_stb, qx_we;
    logic [QX_OW-1:0]  qx_off;
    logic [DW-1:0]     qx_wdata, qx_rdata;

    assign revision_id = REV;

    dwin_seq #(.ID_EN(ID_EN), .QX_EN(QX_EN)) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .leg_stb(leg_stb), .leg_we(leg_we), .leg_off(leg_off),
        .leg_wdata(leg_wdata), .leg_rdata(leg_rdata),
        .xr_stb(xr_stb), .xr_we(xr_we), .xr_idx(xr_idx),
        .xr_wdata(xr_wdata), .xr_rdata(xr_rdata),
        .qx_stb(qx_stb), .qx_we(qx_we), .qx_off(qx_off),
        .qx_wdata(qx_wdata), .qx_rdata(qx_rdata)
    );

    dwin_legacy u_legacy (
        .clk(clk), .rst(rst), .stb(leg_stb), .we(leg_we),
        .off(leg_off), .wdata(leg_wdata), .rdata(leg_rdata)
    );

    dwin_xregs u_xregs (
        .clk(clk), .rst(rst), .stb(xr_stb), .we(xr_we),
        .idx(xr_idx), .wdata(xr_wdata), .rdata(xr_rdata)
    );

    dwin_qext u_qext (
        .clk(clk), .rst(rst), .stb(qx_stb), .we(qx_we), .off(qx_off),
        .wdata(qx_wdata), .rdata(qx_rdata), .big_endian(fb_big_endian)
    );

endmodule

// File: tb/dwin_mmio_window_tb.sv
module dwin_mmio_window_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, resp_valid, fb_big_endian;
    logic [31:0] resp_rdata;
    logic [7:0]  revision_id;
    logic        m_ready, m_valid, m_be;
    logic [31:0] m_rdata;
    logic [7:0]  m_rev;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dwin_mmio_window u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .fb_big_endian(fb_big_endian), .revision_id(revision_id)
    );

    dwin_mmio_window #(.ID_EN(1'b0), .QX_EN(1'b0)) u_min (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_ready(m_ready), .resp_valid(m_valid), .resp_rdata(m_rdata),
        .fb_big_endian(m_be), .revision_id(m_rev)
    );

    function automatic logic [7:0] id_exp(int i);
        if (i > 255) return 8'h00;
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic bus(input logic we, input logic [11:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd,
                       output logic [31:0] rd_min, output int lowcnt);
        @(negedge clk);
        req_valid = 1'b1; req_write = we; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lowcnt = 0; rd = 'x; rd_min = 'x;
        for (int g = 0; g < 40; g++) begin
            if (!req_ready) lowcnt++;
            if (resp_valid) begin
                rd = resp_rdata;
                rd_min = m_rdata;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] wd);
        logic [31:0] r, rm; int n;
        bus(1'b1, a, sz, wd, r, rm, n);
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] r);
        logic [31:0] rm; int n;
        bus(1'b0, a, sz, 32'h0, r, rm, n);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 resp_valid", 32'(resp_valid), 32'd0);
        chk("R1 byte order", 32'(fb_big_endian), 32'd0);
    endtask

    task automatic t_legacy_bytes;
        logic [31:0] r;
        wr(12'h400, 2'd0, 32'h41);
        wr(12'h41F, 2'd0, 32'h7E);
        rd(12'h400, 2'd0, r); chk("R2 port 3C0", r, 32'h41);
        rd(12'h41F, 2'd0, r); chk("R2 port 3DF", r, 32'h7E);
        rd(12'h401, 2'd0, r); chk("R2 untouched port", r, 32'h0);
    endtask

    task automatic t_legacy_order;
        logic [31:0] r;
        wr(12'h404, 2'd1, 32'h5A03);
        rd(12'h405, 2'd0, r); chk("R3 bank[3] via word write", r, 32'h5A);
        wr(12'h404, 2'd1, 32'hC706);
        rd(12'h404, 2'd0, r); chk("R3 index port", r, 32'h06);
        rd(12'h404, 2'd1, r); chk("R3 half read idx/data", r, 32'hC706);
        wr(12'h404, 2'd0, 32'h03);
        rd(12'h405, 2'd0, r); chk("R3 bank[3] kept", r, 32'h5A);
    endtask

    task automatic t_legacy_wide;
        logic [31:0] r, rm; int n;
        wr(12'h408, 2'd2, 32'h44332211);
        rd(12'h408, 2'd0, r); chk("R4 lane0", r, 32'h11);
        rd(12'h409, 2'd0, r); chk("R4 lane1", r, 32'h22);
        rd(12'h40B, 2'd0, r); chk("R4 lane3", r, 32'h44);
        rd(12'h408, 2'd2, r); chk("R4 word read", r, 32'h44332211);
        rd(12'h40A, 2'd1, r); chk("R4 half read", r, 32'h4433);
        wr(12'h402, 2'd2, 32'h9C02_BBAA);
        rd(12'h405, 2'd0, r); chk("R4 word write reaches bank[2]", r, 32'h9C);
        rd(12'h404, 2'd0, r); chk("R4 index from word write", r, 32'h02);
        rd(12'h41E, 2'd2, r); chk("R4 past window end", r, 32'h0000_7E00);
        bus(1'b0, 12'h400, 2'd0, 32'h0, r, rm, n); chk("R11 legacy byte busy", 32'(n), 32'd2);
        bus(1'b0, 12'h400, 2'd1, 32'h0, r, rm, n); chk("R11 legacy half busy", 32'(n), 32'd3);
        bus(1'b0, 12'h400, 2'd2, 32'h0, r, rm, n); chk("R11 legacy word busy", 32'(n), 32'd5);
        bus(1'b0, 12'h400, 2'd3, 32'h0, r, rm, n); chk("R11 size 3 as word", 32'(n), 32'd5);
    endtask

    task automatic t_xregs;
        logic [31:0] r, rm; int n;
        wr(12'h506, 2'd1, 32'hBEEF);
        wr(12'h51E, 2'd2, 32'h1234_ABCD);
        rd(12'h506, 2'd2, r); chk("R5 reg3 word read", r, 32'h0000_BEEF);
        rd(12'h507, 2'd0, r); chk("R5 odd offset same reg", r, 32'h0000_BEEF);
        rd(12'h51E, 2'd1, r); chk("R5 reg15 low half kept", r, 32'h0000_ABCD);
        rd(12'h500, 2'd1, r); chk("R5 reg0 reset", r, 32'h0);
        bus(1'b0, 12'h500, 2'd2, 32'h0, r, rm, n); chk("R11 ext busy", 32'(n), 32'd2);
    endtask

    task automatic t_qext;
        logic [31:0] r;
        rd(12'h600, 2'd2, r); chk("R6 size reg", r, 32'd8);
        rd(12'h604, 2'd2, r); chk("R7 reset code", r, 32'h1E1E_1E1E);
        wr(12'h604, 2'd2, 32'hBEBE_BEBE);
        chk("R7 flag set", 32'(fb_big_endian), 32'd1);
        rd(12'h604, 2'd2, r); chk("R7 big code read", r, 32'hBEBE_BEBE);
        wr(12'h604, 2'd2, 32'h1234_5678);
        chk("R7 stray value ignored", 32'(fb_big_endian), 32'd1);
        wr(12'h604, 2'd2, 32'h1E1E_1E1E);
        chk("R7 flag cleared", 32'(fb_big_endian), 32'd0);
        wr(12'h604, 2'd1, 32'hBEBE_BEBE);
        chk("R6 half write ignored", 32'(fb_big_endian), 32'd0);
        rd(12'h600, 2'd1, r); chk("R6 half read zero", r, 32'h0);
        rd(12'h602, 2'd2, r); chk("R6 unimplemented offset", r, 32'h0);
    endtask

    task automatic t_idtable;
        logic [31:0] r;
        rd(12'h000, 2'd0, r); chk("R8 byte 0", r, 32'(id_exp(0)));
        rd(12'h0FF, 2'd0, r); chk("R8 byte 255", r, 32'(id_exp(255)));
        rd(12'h010, 2'd2, r);
        chk("R8 word merge", r, {id_exp(19), id_exp(18), id_exp(17), id_exp(16)});
        rd(12'h0FE, 2'd2, r);
        chk("R8 past table end", r, {16'h0, id_exp(255), id_exp(254)});
        wr(12'h010, 2'd2, 32'hFFFF_FFFF);
        rd(12'h010, 2'd1, r); chk("R8 read-only", r, {16'h0, id_exp(17), id_exp(16)});
    endtask

    task automatic t_options;
        logic [31:0] r, rm; int n;
        chk("R9 revision with ext", 32'(revision_id), 32'd2);
        chk("R9 revision without ext", 32'(m_rev), 32'd1);
        bus(1'b0, 12'h010, 2'd2, 32'h0, r, rm, n); chk("R9 id table disabled", rm, 32'h0);
        bus(1'b0, 12'h600, 2'd2, 32'h0, r, rm, n); chk("R9 ext disabled size", rm, 32'h0);
        wr(12'h604, 2'd2, 32'hBEBE_BEBE);
        chk("R9 ext disabled write", 32'(m_be), 32'd0);
        bus(1'b0, 12'h604, 2'd2, 32'h0, r, rm, n); chk("R9 ext disabled order", rm, 32'h0);
        wr(12'h604, 2'd2, 32'h1E1E_1E1E);
    endtask

    task automatic t_unmapped;
        logic [31:0] r;
        wr(12'h700, 2'd2, 32'hDEAD_BEEF);
        rd(12'h700, 2'd2, r); chk("R10 unmapped 0x700", r, 32'h0);
        wr(12'h420, 2'd0, 32'h55);
        rd(12'h420, 2'd0, r); chk("R10 unmapped 0x420", r, 32'h0);
        rd(12'h400, 2'd0, r); chk("R10 legacy untouched", r, 32'h41);
        rd(12'h608, 2'd2, r); chk("R10 past ext block", r, 32'h0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_legacy_bytes();
        t_legacy_order();
        t_legacy_wide();
        t_xregs();
        t_qext();
        t_idtable();
        t_options();
        t_unmapped();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule